// File: doc/BRIEF.md
# CRT Horizontal Timing Generator

This block produces the per-scanline horizontal timing of a character-based CRT controller. It divides the pixel clock into character cells of 8 or 9 dots and runs a character counter across the line. It compares that counter with a set of programmed timing fields and drives four signals: display enable, horizontal blanking, horizontal sync, and a one-clock end-of-line strobe that a vertical counter can use.

The block takes all timing fields as parallel register inputs. The two trailing-edge fields, blank end and sync end, are not absolute positions. Each is a short pattern that is matched against the low bits of the counter, starting after the matching leading edge. As a result, blanking or sync can stretch across the end of a line and finish in the next one. An extended mode widens the blank-end match from 6 to 7 bits, and the 7th bit comes from the extension input.

All register inputs are captured into a shadow copy only at the line boundary. A register write in the middle of a line therefore first takes effect on the following scanline.

Top module: `crt_htiming`

## Requirements
- R1: A character cell lasts 8 pixel clocks when `char8_i` is 1 and 9 pixel clocks when it is 0.
- R2: A line is `{ext_i[0], htotal_i} + 5` characters long. `eol_o` is high for exactly one clock: the first clock of character 0 of each new line. It is not raised for the line that starts at reset release.
- R3: `de_o` is high during characters 0 to `dend_i` inclusive, which is `dend_i + 1` characters, and is low whenever `hblank_o` is high.
- R4: `hblank_o` goes high at the character whose index equals `{ext_i[1], bstart_i}`. This can happen before the display end.
- R5: In standard mode (`extmode_i` = 0), blanking ends at the first later character whose low 6 index bits equal `{send_i[7], bend_i[4:0]}`. This character may lie in the next line. `ext_i[6]` has no effect in this mode.
- R6: In extended mode (`extmode_i` = 1), the blank-end match compares 7 index bits with `{ext_i[6], send_i[7], bend_i[4:0]}`.
- R7: Sync becomes active at the character whose index equals `sstart_i`.
- R8: Sync becomes inactive at the first later character whose low 5 index bits equal `send_i[4:0]`. This character may lie in the next line.
- R9: `hsync_o` equals the internal sync-active state XOR `syncneg_i`. This means 1 selects active-low sync.
- R10: Register inputs are used only from the start of the line that follows a change. Both the line length and the field compares of the line in progress keep the old values.
- R11: While `rst` is high, the block holds these values: blanking and sync inactive, `hsync_o` = `syncneg_i`, `de_o` = 1, `eol_o` = 0. After release, character 0 lasts a full cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (dot) clock |
| rst | input | 1 | Synchronous active-high reset |
| htotal_i | input | 8 | Line length field (characters minus 5, low 8 bits) |
| dend_i | input | 8 | Last displayed character index |
| bstart_i | input | 8 | Blank start index, low 8 bits |
| bend_i | input | 8 | Blank end pattern; bits 4:0 used |
| sstart_i | input | 8 | Sync start index |
| send_i | input | 8 | Sync end pattern in bits 4:0; bit 7 is blank-end pattern bit 5 |
| ext_i | input | 8 | Extension: bit 0 total bit 8, bit 1 blank start bit 8, bit 6 blank-end pattern bit 6 |
| char8_i | input | 1 | 1: 8-dot cells, 0: 9-dot cells |
| extmode_i | input | 1 | 1: 7-bit blank-end match, 0: 6-bit match |
| syncneg_i | input | 1 | 1: active-low sync output |
| de_o | output | 1 | Display enable |
| hblank_o | output | 1 | Horizontal blanking |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| eol_o | output | 1 | One-clock end-of-line strobe |

## Verification
Each row of the bench table runs three scanlines, and every output is compared against a character-level model on every clock.

- A text-style 80-column timing checks that the low-bit match ends blanking and sync inside the line.
- The same timing in extended mode leaves the 7th pattern bit unmatched, so blanking must stay on across the wrap. This separates the 6-bit match from the 7-bit match.
- A 9-dot row tells the two cell widths apart.
- A row with both 9th bits set separates full-width compares from truncated ones, and its blank end falls in the next line.
- A row with blank start before display end shows that blanking cuts display enable short.

Directed runs change the registers mid-line to show they are deferred to the next line, and reset the block during active sync.

// File: rtl/crt_htiming_pkg.sv
`timescale 1ns/1ps
package crt_htiming_pkg;
  parameter int HREG_W = 8;   // width of each timing register
  parameter int BEND_W = 7;   // blank-end pattern width in extended mode
  parameter int BSTD_W = 6;   // blank-end pattern width in standard mode
  parameter int SEND_W = 5;   // sync-end pattern width
  parameter int BEND_LO_W = 5; // blank-end bits taken from the blank-end register

  // bit positions inside the extension / sync-end registers (decoded behaviour)
  parameter int EXT_TOT_BIT  = 0;
  parameter int EXT_BST_BIT  = 1;
  parameter int EXT_BEND_BIT = 6;
  parameter int SEND_BEND_BIT = 7;

  typedef struct packed {
    logic [HREG_W-1:0] htotal;
    logic [HREG_W-1:0] dend;
    logic [HREG_W-1:0] bstart;
    logic [HREG_W-1:0] bend;
    logic [HREG_W-1:0] sstart;
    logic [HREG_W-1:0] send;
    logic [HREG_W-1:0] ext;
    logic              char8;
    logic              ext_mode;
    logic              neg;
  } hregs_t;
endpackage

// File: rtl/crt_hshadow.sv
`timescale 1ns/1ps
module crt_hshadow
  import crt_htiming_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  hregs_t live_i,
  output hregs_t sh_o,
  output hregs_t shn_o
);
  hregs_t sh_q;

  // value the shadow takes at the next edge; used by compares made at that edge
  assign shn_o = (rst || load) ? live_i : sh_q;
  assign sh_o  = sh_q;

  always_ff @(posedge clk) begin
    sh_q <= shn_o;
  end

  // R10: between line boundaries the shadow copy never moves
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sh_q));
endmodule

// File: rtl/crt_hdot_div.sv
`timescale 1ns/1ps
module crt_hdot_div #(
  parameter int DOT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic char8,
  output logic stb
);
  localparam logic [DOT_W-1:0] LAST8 = DOT_W'(7);
  localparam logic [DOT_W-1:0] LAST9 = DOT_W'(8);

  logic [DOT_W-1:0] dot_q;
  logic [DOT_W-1:0] dot_last;

  assign dot_last = char8 ? LAST8 : LAST9;
  assign stb      = (dot_q == dot_last);

  always_ff @(posedge clk) begin
    if (rst)      dot_q <= '0;
    else if (stb) dot_q <= '0;
    else          dot_q <= dot_q + DOT_W'(1);
  end

  // R1: the dot position never leaves a 9-dot cell
  assert_dot_range_R1: assert property (@(posedge clk) disable iff (rst)
    dot_q <= LAST9);
endmodule

// File: rtl/crt_hflag.sv
`timescale 1ns/1ps
module crt_hflag #(
  parameter int CNT_W = 10,
  parameter int PAT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic [CNT_W-1:0] start_val,
  input  logic [PAT_W-1:0] end_pat,
  input  logic [PAT_W-1:0] end_mask,
  output logic             flag_nxt,
  output logic             flag_q
);
  logic hit_start;
  logic hit_end;

  assign hit_start = (nxt_cnt == start_val);
  assign hit_end   = (((nxt_cnt[PAT_W-1:0] ^ end_pat) & end_mask) == '0);

  always_comb begin
    flag_nxt = flag_q;
    if (stb) begin
      if (hit_start)            flag_nxt = 1'b1;
      else if (flag_q && hit_end) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

  // R4 / R7: reaching the start position always leaves the flag set
  assert_flag_set_R4_R7: assert property (@(posedge clk) disable iff (rst)
    (stb && hit_start) |=> flag_q);
  // R5 / R8: the flag moves only on character boundaries
  assert_flag_hold_R5_R8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(flag_q));
endmodule

// File: rtl/crt_htiming.sv
`timescale 1ns/1ps
module crt_htiming
  import crt_htiming_pkg::*;
#(
  parameter int CNT_W = HREG_W + 2,
  parameter int DOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HREG_W-1:0] htotal_i,
  input  logic [HREG_W-1:0] dend_i,
  input  logic [HREG_W-1:0] bstart_i,
  input  logic [HREG_W-1:0] bend_i,
  input  logic [HREG_W-1:0] sstart_i,
  input  logic [HREG_W-1:0] send_i,
  input  logic [HREG_W-1:0] ext_i,
  input  logic              char8_i,
  input  logic              extmode_i,
  input  logic              syncneg_i,
  output logic              de_o,
  output logic              hblank_o,
  output logic              hsync_o,
  output logic              eol_o
);
  localparam int TOTAL_ADJ = 5;

  hregs_t live, sh, shn;
  logic stb, wrap;
  logic [CNT_W-1:0] cnt_q, nxt_cnt, last_cnt;
  logic [CNT_W-1:0] bs_full, ss_full, dend_full;
  logic [BEND_W-1:0] bend_pat, bend_msk, send_pat, send_msk;
  logic blank_nxt, blank_q, sync_nxt, sync_q;
  logic de_q, hs_q, eol_q;
  logic unused_sh;

  assign live = '{htotal: htotal_i, dend: dend_i, bstart: bstart_i, bend: bend_i,
                  sstart: sstart_i, send: send_i, ext: ext_i, char8: char8_i,
                  ext_mode: extmode_i, neg: syncneg_i};

  crt_hshadow u_shadow (
    .clk(clk), .rst(rst), .load(wrap), .live_i(live), .sh_o(sh), .shn_o(shn)
  );

  crt_hdot_div #(.DOT_W(DOT_W)) u_dot (
    .clk(clk), .rst(rst), .char8(sh.char8), .stb(stb)
  );

  // character counter, wraps after the last character of the line
  assign last_cnt = CNT_W'({sh.ext[EXT_TOT_BIT], sh.htotal}) + CNT_W'(TOTAL_ADJ - 1);
  assign wrap     = stb && (cnt_q == last_cnt);
  assign nxt_cnt  = wrap ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (stb) cnt_q <= nxt_cnt;
  end

  // compare operands, from the values valid for the character being entered
  assign bs_full   = CNT_W'({shn.ext[EXT_BST_BIT], shn.bstart});
  assign ss_full   = CNT_W'(shn.sstart);
  assign dend_full = CNT_W'(shn.dend);
  assign bend_pat  = {shn.ext[EXT_BEND_BIT], shn.send[SEND_BEND_BIT], shn.bend[BEND_LO_W-1:0]};
  assign bend_msk  = {shn.ext_mode, {BSTD_W{1'b1}}};
  assign send_pat  = BEND_W'(shn.send[SEND_W-1:0]);
  assign send_msk  = BEND_W'({SEND_W{1'b1}});

  crt_hflag #(.CNT_W(CNT_W), .PAT_W(BEND_W)) u_blank (
    .clk(clk), .rst(rst), .stb(stb), .nxt_cnt(nxt_cnt), .start_val(bs_full),
    .end_pat(bend_pat), .end_mask(bend_msk), .flag_nxt(blank_nxt), .flag_q(blank_q)
  );

  crt_hflag #(.CNT_W(CNT_W), .PAT_W(BEND_W)) u_sync (
    .clk(clk), .rst(rst), .stb(stb), .nxt_cnt(nxt_cnt), .start_val(ss_full),
    .end_pat(send_pat), .end_mask(send_msk), .flag_nxt(sync_nxt), .flag_q(sync_q)
  );

  // registered outputs aligned with the counter
  always_ff @(posedge clk) begin
    if (rst) begin
      de_q  <= 1'b1;
      hs_q  <= shn.neg;
      eol_q <= 1'b0;
    end else begin
      eol_q <= wrap;
      if (stb) begin
        de_q <= (nxt_cnt <= dend_full) && !blank_nxt;
        hs_q <= sync_nxt ^ shn.neg;
      end
    end
  end

  assign de_o     = de_q;
  assign hblank_o = blank_q;
  assign hsync_o  = hs_q;
  assign eol_o    = eol_q;

  assign unused_sh = ^{sh, shn, sync_q};

  // R3: display enable is never high during blanking
  assert_de_blank_R3: assert property (@(posedge clk) disable iff (rst)
    hblank_o |-> !de_o);
  // R2: the end-of-line strobe lasts a single clock
  assert_eol_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    eol_o |=> !eol_o);
  // R2: the counter stays put inside a character cell
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(cnt_q));
  // R2: the counter never passes the last character
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_cnt);
endmodule

// File: tb/test_crt_htiming.sv
`timescale 1ns/1ps
module test_crt_htiming;
  import crt_htiming_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic   rst = 1'b1;
  hregs_t cur;
  logic   de, hb, hs, eol;

  crt_htiming i_crt_htiming (
    .clk(clk), .rst(rst),
    .htotal_i(cur.htotal), .dend_i(cur.dend), .bstart_i(cur.bstart),
    .bend_i(cur.bend), .sstart_i(cur.sstart), .send_i(cur.send),
    .ext_i(cur.ext), .char8_i(cur.char8), .extmode_i(cur.ext_mode),
    .syncneg_i(cur.neg),
    .de_o(de), .hblank_o(hb), .hsync_o(hs), .eol_o(eol)
  );

  // field order: htotal dend bstart bend sstart send ext char8 ext_mode neg
  localparam int NV = 5;
  localparam hregs_t CFG [NV] = '{
    '{8'h60, 8'h4F, 8'h50, 8'h83, 8'h52, 8'h9E, 8'h00, 1'b1, 1'b0, 1'b1},
    '{8'h60, 8'h4F, 8'h50, 8'h83, 8'h52, 8'h9E, 8'h00, 1'b1, 1'b1, 1'b1},
    '{8'd20, 8'd15, 8'd17, 8'h17, 8'd19, 8'h16, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'hFF, 8'h00, 8'h05, 8'h02, 8'h08, 8'h03, 1'b1, 1'b0, 1'b0},
    '{8'd11, 8'd13, 8'd12, 8'h0E, 8'd13, 8'h0F, 8'h40, 1'b0, 1'b0, 1'b1}
  };
  localparam int EXP_LINE [NV] = '{808, 808, 225, 2088, 144};

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // character-level model built from the requirements
  hregs_t m_cfg;
  int m_dot, m_pos;
  bit m_blank, m_sync, m_de, m_hs, m_eol;

  function automatic int line_chars(hregs_t c);
    return int'({c.ext[0], c.htotal}) + 5;
  endfunction

  task automatic model_init();
    m_cfg = cur; m_dot = 0; m_pos = 0; m_blank = 0; m_sync = 0;
    m_de = 1; m_hs = cur.neg; m_eol = 0;
  endtask

  task automatic model_step();
    int w, bs;
    bit [6:0] pat, msk, p7;
    w = m_cfg.char8 ? 8 : 9;
    m_eol = 0;
    m_dot++;
    if (m_dot == w) begin
      m_dot = 0;
      if (m_pos == line_chars(m_cfg) - 1) begin
        m_pos = 0; m_eol = 1; m_cfg = cur;
      end else m_pos++;
      bs  = int'({m_cfg.ext[1], m_cfg.bstart});
      pat = {m_cfg.ext[6], m_cfg.send[7], m_cfg.bend[4:0]};
      msk = m_cfg.ext_mode ? 7'h7F : 7'h3F;
      p7  = 7'(m_pos);
      if (m_pos == bs) m_blank = 1;
      else if (m_blank && (((p7 ^ pat) & msk) == 7'h00)) m_blank = 0;
      if (m_pos == int'(m_cfg.sstart)) m_sync = 1;
      else if (m_sync && (p7[4:0] == m_cfg.send[4:0])) m_sync = 0;
      m_de = (m_pos <= int'(m_cfg.dend)) && !m_blank;
      m_hs = m_sync ^ m_cfg.neg;
    end
  endtask

  task automatic check_all();
    chk("R3 display enable", int'(de), int'(m_de));
    chk("R4 R5 R6 blanking", int'(hb), int'(m_blank));
    chk("R7 R8 R9 sync", int'(hs), int'(m_hs));
    chk("R2 end-of-line strobe", int'(eol), int'(m_eol));
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 blank in reset", int'(hb), 0);
    chk("R11 de in reset", int'(de), 1);
    chk("R11 sync idle level in reset", int'(hs), int'(cur.neg));
    chk("R11 eol in reset", int'(eol), 0);
    rst = 1'b0;
    model_init();
    check_all();
  endtask

  // walk n clocks; change inputs after sample chg_at; report eol spacing
  task automatic walk(input int n, input int chg_at, input hregs_t nxt,
                      output int sp1, output int sp2);
    int first;
    first = -1; sp1 = -1; sp2 = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      model_step();
      check_all();
      if (eol) begin
        if (first < 0) begin first = i; sp1 = i; end
        else if (sp2 < 0) sp2 = i - first;
      end
      if (i == chg_at) cur = nxt;
    end
  endtask

  initial begin
    int s1, s2;
    hregs_t mod;
    cur = CFG[0];

    // table walk
    for (int k = 0; k < NV; k++) begin
      cur = CFG[k];
      do_reset();
      walk(3 * EXP_LINE[k] + 10, -1, cur, s1, s2);
      chk($sformatf("R1 R2 first line clocks row %0d", k), s1, EXP_LINE[k]);
      chk($sformatf("R1 R2 second line clocks row %0d", k), s2, EXP_LINE[k]);
    end

    // R10: mid-line change of width, blank start and polarity
    cur = CFG[2];
    do_reset();
    mod = CFG[2];
    mod.bstart = 8'd5; mod.char8 = 1'b1; mod.neg = 1'b1;
    walk(700, 100, mod, s1, s2);
    chk("R10 old line length kept", s1, 225);
    chk("R10 new line length applied", s2, 200);

    // R11: reset in the middle of active sync
    cur = CFG[0];
    do_reset();
    walk(700, -1, cur, s1, s2);
    chk("R4 blank active before reset", int'(hb), 1);
    chk("R9 active-low sync before reset", int'(hs), 0);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule